// File: doc/BRIEF.md
# ACPI Power Management Register Block

This block is a bus-slave register file that holds the fixed power-management registers of a system controller. It has a free-running power-management timer that advances on an external tick strobe (a 3,579,545 Hz rate generated outside the block), an event status register with write-one-to-clear bits, an event enable register and a control register. A level-sensitive system control interrupt (SCI) goes high whenever an enabled event is pending.

A byte-wide side port holds an APM command byte and an APM status byte. Writing the command byte can switch SCI routing on or off and can raise a one-cycle SMI request. Writing the control register with its sleep-enable bit set decodes a sleep type and produces one-cycle shutdown or reset requests. Those pulses are acted on elsewhere.

Reads have no side effects and return data combinationally for the presented offset. All writes take effect at the next clock edge.

Top module: `pm_regblk`

## Requirements
- R1: The timer is TMR_W bits wide (24 by default) and resets to zero. It advances by one, wrapping modulo 2^TMR_W, in each cycle where `tick_en` is high. It reads at offset 0x08 on the 32-bit read bus with every bit above the timer width zero.
- R2: After reset every register reads zero. Status reads at offset 0x00, enable at 0x02 and control at 0x04. Every other offset reads zero, and writes to offsets other than 0x00, 0x02 and 0x04 change nothing.
- R3: A write to offset 0x00 clears each status bit whose data bit is 1 and leaves each status bit whose data bit is 0 unchanged.
- R4: Status bit 0 is set in the cycle after a tick that changes the timer's top bit, that is, each time the count crosses a multiple of 2^(TMR_W-1).
- R5: `sci` is high exactly while (status AND enable) has any of bits 0, 5, 8 or 10 set.
- R6: A write to offset 0x04 stores the data with bit 13 forced to 0, so bit 13 always reads 0.
- R7: A control write with bit 13 set decodes bits 12:10 as the sleep type, and the request pulse appears for one cycle in the cycle after the write. Type 0 pulses `shutdown_req`. Type 1 sets status bits 15 and 8 and pulses `reset_req`. Other types do nothing beyond storing the control value.
- R8: A `pwrbtn_evt` cycle sets status bit 8 only when enable bit 8 is set, and otherwise has no effect.
- R9: An APM write with `apm_port_sel`=0 stores the command byte. The value 0xF1 sets control bit 0 and 0xF0 clears it, and this takes effect after any control write in the same cycle. An APM write with `apm_port_sel`=1 stores the status byte. `apm_rdata` returns the byte that `apm_port_sel` selects.
- R10: An APM command write (`apm_port_sel`=0) pulses `smi_req` for one cycle in the next cycle only when `smi_cfg_en` is high.
- R11: When hardware sets a status bit in the same cycle that software writes a 1 to clear it, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timer advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset within the 64-byte window |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| apm_wr | input | 1 | APM port write strobe |
| apm_port_sel | input | 1 | 0 selects the command byte, 1 selects the status byte |
| apm_wdata | input | 8 | APM write data |
| apm_rdata | output | 8 | APM read data |
| smi_cfg_en | input | 1 | External SMI enable configuration bit |
| pwrbtn_evt | input | 1 | Power-button event strobe |
| sci | output | 1 | Level system control interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request |
| smi_req | output | 1 | One-cycle SMI request |

## Verification
Several pairs of functions can fall in the same cycle. A hardware status set can coincide with a software write-one-to-clear. A control write can coincide with an APM enable or disable command.

For the status collision, the bench counts the timer up to one tick before its top bit flips. It then issues that tick together with a write that clears bit 0. It separately drives a power-button event together with a clear of bit 8. The status read-back must still show the bit set.

A random phase mixes all strobes, including simultaneous control and APM writes. Every cycle is judged against a behavioural model that applies the control write first and the APM command second.

// File: rtl/pm_regblk_pkg.sv
package pm_regblk_pkg;
   localparam logic [5:0] OFS_STS = 6'h00;
   localparam logic [5:0] OFS_EN  = 6'h02;
   localparam logic [5:0] OFS_CTL = 6'h04;
   localparam logic [5:0] OFS_TMR = 6'h08;

   localparam int BIT_TMR_OVF = 0;
   localparam int BIT_PWRBTN  = 8;
   localparam int BIT_RESUME  = 15;
   localparam int BIT_SCI_EN  = 0;
   localparam int BIT_SLP_EN  = 13;
   localparam int SLP_TYP_LO  = 10;

   localparam logic [15:0] SCI_SRC_MASK = 16'h0521;

   localparam logic [7:0] APM_SCI_ON  = 8'hF1;
   localparam logic [7:0] APM_SCI_OFF = 8'hF0;

   typedef enum logic [2:0] {
      SLP_POWER_OFF = 3'd0,
      SLP_SUSPEND   = 3'd1
   } slp_typ_e;
endpackage

// File: rtl/pm_tick_timer.sv
module pm_tick_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [TMR_W-1:0] count,
   output logic             ovf_evt
);
   localparam int LOW_W = TMR_W - 1;

   if (TMR_W < 2 || TMR_W > 32) begin : g_bad_width
      $error("pm_tick_timer: TMR_W must lie in 2..32");
   end

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_q + 1'b1;
   end

   // top bit flips exactly when every lower bit is one at a tick
   assign ovf_evt = tick_en & (&cnt_q[LOW_W-1:0]);
   assign count   = cnt_q;

   a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> cnt_q == $past(cnt_q) + 1'b1);
   a_r1_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt_q));
   a_r4_ovf_flip: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1]));
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status #(
   parameter int          REG_W    = 16,
   parameter logic [15:0] SCI_MASK = 16'h0521
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_we,
   input  logic [REG_W-1:0] clr_mask,
   input  logic [REG_W-1:0] set_mask,
   input  logic             en_we,
   input  logic [REG_W-1:0] en_wdata,
   output logic [REG_W-1:0] sts,
   output logic [REG_W-1:0] en,
   output logic             sci
);
   if (REG_W != 16) begin : g_bad_width
      $error("pm_evt_status: REG_W must be 16");
   end

   logic [REG_W-1:0] sts_q;
   logic [REG_W-1:0] en_q;

   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      logic clr_hit;
      assign clr_hit = clr_we & clr_mask[i];

      always_ff @(posedge clk) begin
         if (!rst_n)           sts_q[i] <= 1'b0;
         else if (set_mask[i]) sts_q[i] <= 1'b1;
         else if (clr_hit)     sts_q[i] <= 1'b0;
      end

      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_mask[i] |=> sts_q[i]);
      a_r3_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_mask[i] && !set_mask[i]) |=> !sts_q[i]);
      a_r3_keep_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_mask[i] && !(clr_we && clr_mask[i])) |=> $stable(sts_q[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   assign sts = sts_q;
   assign en  = en_q;
   assign sci = |(sts_q & en_q & SCI_MASK[REG_W-1:0]);
endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
   import pm_regblk_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int APM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [REG_W-1:0] ctl_wdata,
   input  logic             apm_wr,
   input  logic             apm_sel,
   input  logic [APM_W-1:0] apm_wdata,
   input  logic             smi_cfg_en,
   output logic [REG_W-1:0] ctl,
   output logic [APM_W-1:0] apm_cmd,
   output logic [APM_W-1:0] apm_sts,
   output logic             resume_set,
   output logic             shutdown_req,
   output logic             reset_req,
   output logic             smi_req
);
   if (APM_W != 8 || REG_W != 16) begin : g_bad_width
      $error("pm_sleep_ctl: APM_W must be 8 and REG_W 16");
   end

   logic [REG_W-1:0] ctl_q, ctl_wr_val, ctl_d;
   logic [APM_W-1:0] cmd_q, apms_q;
   logic [2:0]       slp_typ;
   logic             slp_go, cmd_wr, sd_q, rs_q, smi_q;

   assign slp_typ    = ctl_wdata[SLP_TYP_LO +: 3];
   assign slp_go     = ctl_we & ctl_wdata[BIT_SLP_EN];
   assign cmd_wr     = apm_wr & ~apm_sel;
   assign resume_set = slp_go & (slp_typ == SLP_SUSPEND);

   always_comb begin
      ctl_wr_val = ctl_wdata;
      ctl_wr_val[BIT_SLP_EN] = 1'b0;
      ctl_d = ctl_we ? ctl_wr_val : ctl_q;
      if (cmd_wr && apm_wdata == APM_SCI_ON)  ctl_d[BIT_SCI_EN] = 1'b1;
      if (cmd_wr && apm_wdata == APM_SCI_OFF) ctl_d[BIT_SCI_EN] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         cmd_q  <= '0;
         apms_q <= '0;
         sd_q   <= 1'b0;
         rs_q   <= 1'b0;
         smi_q  <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         if (cmd_wr)            cmd_q  <= apm_wdata;
         if (apm_wr && apm_sel) apms_q <= apm_wdata;
         sd_q  <= slp_go & (slp_typ == SLP_POWER_OFF);
         rs_q  <= resume_set;
         smi_q <= cmd_wr & smi_cfg_en;
      end
   end

   assign ctl          = ctl_q;
   assign apm_cmd      = cmd_q;
   assign apm_sts      = apms_q;
   assign shutdown_req = sd_q;
   assign reset_req    = rs_q;
   assign smi_req      = smi_q;

   a_r6_slp_not_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[BIT_SLP_EN]);
   a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sd_q, rs_q}));
   a_r9_apm_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && apm_wdata == APM_SCI_ON) |=> ctl_q[BIT_SCI_EN]);
   a_r9_apm_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && apm_wdata == APM_SCI_OFF) |=> !ctl_q[BIT_SCI_EN]);
   a_r10_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
      smi_q |-> $past(apm_wr && !apm_sel && smi_cfg_en));
endmodule

// File: rtl/pm_regblk.sv
module pm_regblk
   import pm_regblk_pkg::*;
#(
   parameter int TMR_W  = 24,
   parameter int REG_W  = 16,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int APM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              apm_wr,
   input  logic              apm_port_sel,
   input  logic [APM_W-1:0]  apm_wdata,
   output logic [APM_W-1:0]  apm_rdata,
   input  logic              smi_cfg_en,
   input  logic              pwrbtn_evt,
   output logic              sci,
   output logic              shutdown_req,
   output logic              reset_req,
   output logic              smi_req
);
   if (ADDR_W != 6 || TMR_W > DATA_W || REG_W > DATA_W) begin : g_bad_cfg
      $error("pm_regblk: window must be 64 bytes and registers fit the read bus");
   end

   logic [TMR_W-1:0] tmr;
   logic             ovf_evt, resume_set;
   logic [REG_W-1:0] sts, en, ctl, set_mask;
   logic [APM_W-1:0] apm_cmd, apm_sts;
   logic             sel_sts, sel_en, sel_ctl, sel_tmr;

   assign sel_sts = bus_addr == OFS_STS;
   assign sel_en  = bus_addr == OFS_EN;
   assign sel_ctl = bus_addr == OFS_CTL;
   assign sel_tmr = bus_addr == OFS_TMR;

   pm_tick_timer #(.TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .count(tmr), .ovf_evt(ovf_evt)
   );

   always_comb begin
      set_mask = '0;
      set_mask[BIT_TMR_OVF] = ovf_evt;
      set_mask[BIT_PWRBTN]  = (pwrbtn_evt & en[BIT_PWRBTN]) | resume_set;
      set_mask[BIT_RESUME]  = resume_set;
   end

   pm_evt_status #(.REG_W(REG_W), .SCI_MASK(SCI_SRC_MASK)) u_status (
      .clk(clk), .rst_n(rst_n),
      .clr_we(bus_wr & sel_sts), .clr_mask(bus_wdata), .set_mask(set_mask),
      .en_we(bus_wr & sel_en), .en_wdata(bus_wdata),
      .sts(sts), .en(en), .sci(sci)
   );

   pm_sleep_ctl #(.REG_W(REG_W), .APM_W(APM_W)) u_sleep (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(bus_wr & sel_ctl), .ctl_wdata(bus_wdata),
      .apm_wr(apm_wr), .apm_sel(apm_port_sel), .apm_wdata(apm_wdata),
      .smi_cfg_en(smi_cfg_en),
      .ctl(ctl), .apm_cmd(apm_cmd), .apm_sts(apm_sts),
      .resume_set(resume_set),
      .shutdown_req(shutdown_req), .reset_req(reset_req), .smi_req(smi_req)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_sts) bus_rdata = DATA_W'(sts);
      if (sel_en)  bus_rdata = DATA_W'(en);
      if (sel_ctl) bus_rdata = DATA_W'(ctl);
      if (sel_tmr) bus_rdata = DATA_W'(tmr);
   end

   assign apm_rdata = apm_port_sel ? apm_sts : apm_cmd;

   a_r8_pwrbtn_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrbtn_evt && en[BIT_PWRBTN]) |=> sts[BIT_PWRBTN]);
   a_r7_resume_flags: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (sts[BIT_RESUME] && sts[BIT_PWRBTN]));
endmodule

// File: tb/pm_regblk_tb.sv
`timescale 1ns/1ps
module pm_regblk_tb;
   localparam int TW = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_en = 0, bus_wr = 0, apm_wr = 0, apm_port_sel = 0;
   logic smi_cfg_en = 0, pwrbtn_evt = 0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [7:0]  apm_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  apm_rdata;
   logic sci, shutdown_req, reset_req, smi_req;

   always #5 clk = ~clk;

   pm_regblk #(.TMR_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .apm_wr(apm_wr), .apm_port_sel(apm_port_sel), .apm_wdata(apm_wdata),
      .apm_rdata(apm_rdata), .smi_cfg_en(smi_cfg_en), .pwrbtn_evt(pwrbtn_evt),
      .sci(sci), .shutdown_req(shutdown_req), .reset_req(reset_req),
      .smi_req(smi_req)
   );

   int n_chk = 0, n_fail = 0, n_cyc = 0;
   bit done = 0;

   // behavioural reference state
   int unsigned m_tmr = 0;
   logic [15:0] m_sts = 0, m_en = 0, m_ctl = 0;
   logic [7:0]  m_cmd = 0, m_apms = 0;
   bit m_sd = 0, m_rs = 0, m_smi = 0;

   logic [31:0] last_rd;
   logic [7:0]  last_apm;
   bit last_sci, last_sd, last_rs, last_smi;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      case (a)
         6'h00: return {16'h0, m_sts};
         6'h02: return {16'h0, m_en};
         6'h04: return {16'h0, m_ctl};
         6'h08: return m_tmr;
         default: return 32'h0;
      endcase
   endfunction

   // one clock: drive at negedge, compare, advance model at the edge
   task automatic cyc(input bit wr, input logic [5:0] a, input logic [15:0] wd,
                      input bit tk, input bit pb, input bit aw, input bit as,
                      input logic [7:0] ad, input bit cfg);
      int unsigned n_tmr;
      logic [15:0] n_sts, n_en, n_ctl, setm, clrm;
      logic [7:0]  n_cmd, n_apms;
      bit ovf, n_sd, n_rs, n_smi, slp;
      bus_wr = wr; bus_addr = a; bus_wdata = wd; tick_en = tk;
      pwrbtn_evt = pb; apm_wr = aw; apm_port_sel = as; apm_wdata = ad;
      smi_cfg_en = cfg;
      #1;
      last_rd = bus_rdata; last_apm = apm_rdata; last_sci = sci;
      last_sd = shutdown_req; last_rs = reset_req; last_smi = smi_req;
      chk(bus_rdata == exp_rd(a), (a == 6'h08) ? "R1 timer read" : "R2 register read",
          bus_rdata, exp_rd(a));
      chk(sci == ((m_sts & m_en & 16'h0521) != 0), "R5 sci level", sci,
          (m_sts & m_en & 16'h0521) != 0);
      chk(shutdown_req == m_sd, "R7 shutdown pulse", shutdown_req, m_sd);
      chk(reset_req == m_rs, "R7 reset pulse", reset_req, m_rs);
      chk(smi_req == m_smi, "R10 smi pulse", smi_req, m_smi);
      chk(apm_rdata == (as ? m_apms : m_cmd), "R9 apm read", apm_rdata,
          as ? m_apms : m_cmd);
      // next state
      ovf   = tk && ((m_tmr % (1 << (TW-1))) == (1 << (TW-1)) - 1);
      n_tmr = tk ? (m_tmr + 1) % (1 << TW) : m_tmr;
      slp   = wr && a == 6'h04 && wd[13];
      setm  = 0;
      if (ovf) setm[0] = 1;
      if (pb && m_en[8]) setm[8] = 1;
      if (slp && wd[12:10] == 3'd1) setm = setm | 16'h8100;
      clrm  = (wr && a == 6'h00) ? wd : 16'h0;
      n_sts = (m_sts & ~clrm) | setm;
      n_en  = (wr && a == 6'h02) ? wd : m_en;
      n_ctl = (wr && a == 6'h04) ? (wd & 16'hDFFF) : m_ctl;
      if (aw && !as && ad == 8'hF1) n_ctl[0] = 1;
      if (aw && !as && ad == 8'hF0) n_ctl[0] = 0;
      n_cmd  = (aw && !as) ? ad : m_cmd;
      n_apms = (aw && as) ? ad : m_apms;
      n_sd   = slp && wd[12:10] == 3'd0;
      n_rs   = slp && wd[12:10] == 3'd1;
      n_smi  = aw && !as && cfg;
      @(posedge clk);
      m_tmr = n_tmr; m_sts = n_sts; m_en = n_en; m_ctl = n_ctl;
      m_cmd = n_cmd; m_apms = n_apms; m_sd = n_sd; m_rs = n_rs; m_smi = n_smi;
      @(negedge clk);
   endtask

   task automatic rd(input logic [5:0] a);
      cyc(0, a, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      cyc(1, a, d, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic apm(input bit s, input logic [7:0] d, input bit cfg);
      cyc(0, 0, 0, 0, 0, 1, s, d, cfg);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         n_cyc++;
         if (n_cyc > 150000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", n_cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 reset state and unmapped offsets
      rd(6'h00); chk(last_rd == 0, "R2 status after reset", last_rd, 0);
      rd(6'h02); chk(last_rd == 0, "R2 enable after reset", last_rd, 0);
      rd(6'h04); chk(last_rd == 0, "R2 control after reset", last_rd, 0);
      rd(6'h08); chk(last_rd == 0, "R1 timer after reset", last_rd, 0);
      wr(6'h06, 16'hFFFF);
      rd(6'h06); chk(last_rd == 0, "R2 unmapped read", last_rd, 0);
      // R6 / R7 sleep type 3: stored minus bit 13, no request
      wr(6'h04, 16'h2C05);
      rd(6'h04);
      chk(last_rd == 32'h0C05, "R6 sleep bit dropped", last_rd, 32'h0C05);
      chk(!last_sd && !last_rs, "R7 type 3 no request", {last_sd, last_rs}, 0);
      // R9 APM command toggles SCI enable
      apm(0, 8'hF0, 0); rd(6'h04);
      chk(last_rd == 32'h0C04, "R9 F0 clears bit0", last_rd, 32'h0C04);
      apm(0, 8'hF1, 0); rd(6'h04);
      chk(last_rd == 32'h0C05, "R9 F1 sets bit0", last_rd, 32'h0C05);
      apm(1, 8'h5A, 0);
      cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
      chk(last_apm == 8'h5A, "R9 apm status byte", last_apm, 8'h5A);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk(last_apm == 8'hF1, "R9 apm command byte", last_apm, 8'hF1);
      // R10 SMI only with configuration bit
      apm(0, 8'h12, 0); rd(6'h00);
      chk(!last_smi, "R10 no smi without cfg", last_smi, 0);
      apm(0, 8'h12, 1); rd(6'h00);
      chk(last_smi, "R10 smi with cfg", last_smi, 1);
      // R8 power button gating
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); rd(6'h00);
      chk(last_rd == 0, "R8 masked power button", last_rd, 0);
      wr(6'h02, 16'h0100);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); rd(6'h00);
      chk(last_rd == 32'h0100, "R8 enabled power button", last_rd, 32'h0100);
      chk(last_sci, "R5 sci on power button", last_sci, 1);
      // R3 write-one-to-clear
      wr(6'h00, 16'h0000); rd(6'h00);
      chk(last_rd == 32'h0100, "R3 zero write keeps", last_rd, 32'h0100);
      wr(6'h00, 16'hFEFF); rd(6'h00);
      chk(last_rd == 32'h0100, "R3 other ones keep", last_rd, 32'h0100);
      wr(6'h00, 16'h0100); rd(6'h00);
      chk(last_rd == 0 && !last_sci, "R3 clear bit8", last_rd, 0);
      // R11 set and clear in one cycle
      cyc(1, 6'h00, 16'h0100, 0, 1, 0, 0, 0, 0); rd(6'h00);
      chk(last_rd == 32'h0100, "R11 power button beats clear", last_rd, 32'h0100);
      wr(6'h00, 16'hFFFF);
      // R7 sleep type 0 and 1
      wr(6'h04, 16'h2000); rd(6'h04);
      chk(last_sd && !last_rs, "R7 type 0 shutdown", {last_sd, last_rs}, 2'b10);
      chk(last_rd == 0, "R6 control after type 0", last_rd, 0);
      wr(6'h04, 16'h2400); rd(6'h00);
      chk(last_rs && !last_sd, "R7 type 1 reset", {last_sd, last_rs}, 2'b01);
      chk(last_rd == 32'h8100, "R7 resume flags", last_rd, 32'h8100);
      wr(6'h00, 16'h8100);
      // R4 / R11 / R1 timer overflow
      wr(6'h02, 16'h0001);
      for (int i = 0; i < (1 << (TW-1)) - 1; i++) cyc(0, 6'h08, 0, 1, 0, 0, 0, 0, 0);
      rd(6'h08);
      chk(last_rd == (1 << (TW-1)) - 1, "R1 timer count", last_rd, (1 << (TW-1)) - 1);
      rd(6'h00); chk(last_rd == 0, "R4 no early overflow", last_rd, 0);
      cyc(1, 6'h00, 16'h0001, 1, 0, 0, 0, 0, 0); rd(6'h00);
      chk(last_rd == 1, "R11 overflow beats clear", last_rd, 1);
      chk(last_sci, "R5 sci on overflow", last_sci, 1);
      wr(6'h00, 16'h0001);
      for (int i = 0; i < (1 << (TW-1)); i++) cyc(0, 6'h00, 0, 1, 0, 0, 0, 0, 0);
      rd(6'h08); chk(last_rd == 0, "R1 timer wrap", last_rd, 0);
      rd(6'h00); chk(last_rd == 1, "R4 overflow on wrap", last_rd, 1);
      // random phase, model compared every cycle
      for (int i = 0; i < 4000; i++) begin
         logic [5:0] a;
         logic [15:0] d;
         logic [7:0] ad;
         case ($urandom % 7)
            0: a = 6'h00; 1: a = 6'h02; 2: a = 6'h04; 3: a = 6'h08;
            4: a = 6'h01; 5: a = 6'h06; default: a = 6'h3F;
         endcase
         d  = 16'($urandom);
         ad = ($urandom % 3 == 0) ? 8'hF1 : (($urandom % 2 == 0) ? 8'hF0 : 8'($urandom));
         cyc($urandom % 4 == 0, a, d, $urandom % 2 == 0, $urandom % 8 == 0,
             $urandom % 5 == 0, $urandom % 3 == 0, ad, $urandom % 2 == 0);
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule